// File: doc/BRIEF.md
# Per-CPU GPIO Interrupt Router

This block sits behind the pending-status word of a GPIO bank and steers each pending line to the interrupt inputs of one or more processors. Every CPU owns one mask word. Its bits follow the GPIO lines one for one. A CPU's interrupt output rises when at least one line is both pending and enabled in that CPU's word. A line may be enabled in several words at the same time, so software can send it to several CPUs at once. It can also give each CPU a disjoint share of the lines.

The mask words are reached through a plain 32-bit read/write register port. Word `c` sits at byte offset `4*c`. Software changes the routing of one line by reading each CPU's word, changing one bit, and writing the word back. The bytes of a mask word follow the same port ordering as the bank's one-bit-per-line registers. With the default ordering, port 0 (lines 0-7) sits in the most significant byte. After reset every line is routed to every CPU. Parameters set the number of CPUs, the number of lines and the port ordering.

Top module: `gpio_irq_cpu_router`

## Requirements
- R1: After reset every mask word reads back as all lines enabled (32'hFFFFFFFF with 32 lines), and every `irq_o` bit is 0.
- R2: `irq_o[c]` equals, one clock after sampling, the OR over all lines of (`status_i` AND CPU c's mask); it is 0 one cycle after `status_i` is all zero.
- R3: A write (`bus_sel`=1, `bus_wr`=1) to byte offset 4*c replaces CPU c's whole mask word, leaves all other words unchanged, and reads back the same value.
- R4: With `HIGH_PORT_FIRST`=1 (default), line 8*p+b is held in bus bit 8*(3-p)+b of a mask word; with 0, line n is bus bit n.
- R5: An access whose word index is NUM_CPUS or above, or whose address bits [1:0] are not zero, reads 32'h0 and its write changes no mask.
- R6: A mask write is seen on `irq_o` at the second rising edge after the write is driven: the output is unchanged right after the write edge and reflects the new mask one edge later.
- R7: A line enabled in several mask words drives all of those CPUs' outputs at once, and CPUs whose words block it stay low.
- R8: A line whose mask bit is 0 in a CPU's word never raises that CPU's output, however long it stays pending.
- R9: A cycle with `bus_wr`=0, or with `bus_sel`=0, changes no mask word. `bus_rdata` is 0 whenever `bus_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_i | input | NUM_LINES | Pending status, one bit per GPIO line |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the mask region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | NUM_CPUS | Registered interrupt request per CPU |

## Verification
A corrupted mask word appears at the ports in two places. Its next read returns the wrong value at once. One clock after a matching line is pending, a CPU output is high or low when it should not be. A mis-decoded address shows up as a second CPU's word changing, or as an out-of-range offset returning data. Both appear on the read that follows the bad write. A byte-lane swap fault shows only when a line sits in a port other than the one that shares its bus byte. For that reason the stimulus pairs status lines in port 0 and port 3 with masks placed on the opposite lanes.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int BUS_W  = 32;
  localparam int PORT_W = 8;
  localparam int PORTS  = BUS_W / PORT_W;

  // Maps between the bus image of a mask word and line order.
  // The mapping is its own inverse, so both directions use it.
  function automatic logic [BUS_W-1:0] reorder_ports(input logic [BUS_W-1:0] w,
                                                     input bit high_first);
    logic [BUS_W-1:0] r;
    for (int p = 0; p < PORTS; p++) begin
      if (high_first) r[p*PORT_W +: PORT_W] = w[(PORTS-1-p)*PORT_W +: PORT_W];
      else            r[p*PORT_W +: PORT_W] = w[p*PORT_W +: PORT_W];
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES       = 32,
  parameter int NUM_CPUS        = 4,
  parameter int ADDR_W          = 6,
  parameter bit HIGH_PORT_FIRST = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [BUS_W-1:0]              bus_wdata,
  output logic [BUS_W-1:0]              bus_rdata,
  output logic [NUM_CPUS*NUM_LINES-1:0] mask_flat
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     word_idx;
  logic                 aligned;
  logic                 idx_in_range;
  logic                 wr_fire;
  logic [BUS_W-1:0]     wdata_lines;
  logic [NUM_LINES-1:0] wr_lines;
  logic [NUM_CPUS-1:0]  wr_hit;
  logic [NUM_LINES-1:0] mask_q [NUM_CPUS];
  logic [BUS_W-1:0]     rd_lines;

  assign word_idx     = bus_addr[ADDR_W-1:2];
  assign aligned      = (bus_addr[1:0] == 2'b00);
  assign idx_in_range = aligned && (32'(word_idx) < 32'(NUM_CPUS));
  assign wr_fire      = bus_sel && bus_wr;
  assign wdata_lines  = reorder_ports(bus_wdata, HIGH_PORT_FIRST);
  assign wr_lines     = wdata_lines[NUM_LINES-1:0];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_word
    assign wr_hit[c] = wr_fire && idx_in_range && (word_idx == IDX_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n)         mask_q[c] <= '1;
      else if (wr_hit[c]) mask_q[c] <= wr_lines;
    end

    assign mask_flat[c*NUM_LINES +: NUM_LINES] = mask_q[c];

    // R3: a write lands only in the addressed word
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[c] |=> mask_q[c] == $past(wr_lines));
    // R3 / R9: words not hit keep their value
    assert_word_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[c] |=> $stable(mask_q[c]));
  end

  always_comb begin
    rd_lines = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (word_idx == IDX_W'(c)) rd_lines[NUM_LINES-1:0] = mask_q[c];
    end
  end

  assign bus_rdata = (bus_sel && idx_in_range) ? reorder_ports(rd_lines, HIGH_PORT_FIRST)
                                               : '0;

  assert_single_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
  assert_oor_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !idx_in_range) |=> $stable(mask_flat));
  assert_oor_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !idx_in_range) |-> bus_rdata == '0);
  assert_idle_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0);

endmodule

// File: rtl/irq_route_gate.sv
module irq_route_gate #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] status_i,
  input  logic [NUM_LINES-1:0] mask_i,
  output logic                 irq_o
);

  function automatic logic any_routed(input logic [NUM_LINES-1:0] st,
                                      input logic [NUM_LINES-1:0] mk);
    return |(st & mk);
  endfunction

  logic hit_now;
  logic irq_q;

  assign hit_now = any_routed(status_i, mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hit_now;
  end

  assign irq_o = irq_q;

  assert_quiet_without_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i == '0) |=> !irq_o);
  assert_rise_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(status_i != '0));
  assert_blocked_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |=> !irq_o);

endmodule

// File: rtl/gpio_irq_cpu_router.sv
module gpio_irq_cpu_router
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES       = 32,
  parameter int NUM_CPUS        = 4,
  parameter int ADDR_W          = 6,
  parameter bit HIGH_PORT_FIRST = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] status_i,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CPUS-1:0]  irq_o
);

  localparam int MASK_BITS = NUM_CPUS * NUM_LINES;

  logic [MASK_BITS-1:0] mask_flat;

  irq_route_regs #(
    .NUM_LINES       (NUM_LINES),
    .NUM_CPUS        (NUM_CPUS),
    .ADDR_W          (ADDR_W),
    .HIGH_PORT_FIRST (HIGH_PORT_FIRST)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask_flat (mask_flat)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    irq_route_gate #(
      .NUM_LINES (NUM_LINES)
    ) gate_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_i),
      .mask_i   (mask_flat[c*NUM_LINES +: NUM_LINES]),
      .irq_o    (irq_o[c])
    );
  end

  // R7: outputs of different CPUs are independent, none rises without pending status
  assert_no_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i == '0) |=> (irq_o == '0));

endmodule

// File: tb/gpio_irq_cpu_router_tb_top.sv
module gpio_irq_cpu_router_tb_top;

  localparam int NL = 32;
  localparam int NC = 4;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] status_i = '0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_irq_cpu_router #(
    .NUM_LINES (NL), .NUM_CPUS (NC), .ADDR_W (AW), .HIGH_PORT_FIRST (1'b1)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .status_i (status_i),
    .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq_o (irq_o)
  );

  // {status, mask3, mask2, mask1, mask0}, masks in bus image
  localparam logic [159:0] VECS [0:7] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0100_0000},
    {32'h0100_0000, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0100_0000},
    {32'h00FF_0000, 32'h0000_8000, 32'h0000_0080, 32'h0000_FF00, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h8000_0000, 32'h8000_0000, 32'h0000_0080, 32'h0000_0001, 32'hFF00_0000},
    {32'h0000_0100, 32'h0001_0000, 32'h0000_0100, 32'h00FF_0000, 32'hFFFF_FFFF},
    {32'h0000_8001, 32'h0080_0000, 32'h8000_0000, 32'h0100_0000, 32'h0000_00FF}
  };

  // R4 restated: line 8p+b lives at bus bit 8*(3-p)+b
  function automatic logic expect_irq(input logic [31:0] st, input logic [31:0] mbus);
    for (int l = 0; l < NL; l++) begin
      if (st[l] && mbus[8*(3 - l/8) + (l%8)]) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic read_check(input logic [AW-1:0] a, input logic [31:0] exp,
                            input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(bus_rdata == exp, req, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    n_fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks + 1, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] st;
    logic [31:0] mk [NC];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int c = 0; c < NC; c++) read_check(AW'(4*c), 32'hFFFF_FFFF, "R1 mask reset");
    #1 check(irq_o == '0, "R1 irq reset", 32'(irq_o), 32'h0);

    // R2 R3 R4 R7 R8: table of vectors
    for (int v = 0; v < 8; v++) begin
      st = VECS[v][159:128];
      for (int c = 0; c < NC; c++) begin
        mk[c] = VECS[v][32*c +: 32];
        bus_write(AW'(4*c), mk[c]);
      end
      status_i = st;
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
        logic e;
        e = expect_irq(st, mk[c]);
        check(irq_o[c] == e, "R2/R4/R7/R8 irq route", 32'(irq_o[c]), 32'(e));
      end
      read_check(AW'(4*(v%NC)), mk[v%NC], "R3 readback");
    end

    // R6: timing of a mask change
    for (int c = 0; c < NC; c++) bus_write(AW'(4*c), 32'h0);
    status_i = 32'h0000_0001;
    @(negedge clk);
    check(irq_o == '0, "R8 all blocked", 32'(irq_o), 32'h0);
    bus_write(AW'(0), 32'h0100_0000);
    check(irq_o[0] == 1'b0, "R6 not yet visible", 32'(irq_o[0]), 32'h0);
    @(negedge clk);
    check(irq_o == 4'b0001, "R6 visible next edge", 32'(irq_o), 32'h1);

    // R5: out-of-range and misaligned accesses
    bus_write(AW'(16), 32'hFFFF_FFFF);
    bus_write(AW'(2), 32'hFFFF_FFFF);
    read_check(AW'(16), 32'h0, "R5 oor read zero");
    read_check(AW'(60), 32'h0, "R5 top read zero");
    read_check(AW'(1), 32'h0, "R5 misaligned read zero");
    read_check(AW'(0), 32'h0100_0000, "R5 cpu0 kept");
    read_check(AW'(4), 32'h0, "R5 cpu1 kept");
    #1 check(irq_o == 4'b0001, "R5 irq unchanged", 32'(irq_o), 32'h1);

    // R9: reads and deselected writes leave masks alone
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(0); bus_wdata = 32'h0;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = AW'(4); bus_wdata = 32'hFFFF_FFFF;
    #1 check(bus_rdata == 32'h0, "R9 rdata idle", bus_rdata, 32'h0);
    @(negedge clk);
    bus_wr = 1'b0;
    read_check(AW'(0), 32'h0100_0000, "R9 read no write");
    read_check(AW'(4), 32'h0, "R9 deselected no write");
    #1 check(irq_o == 4'b0001, "R9 irq unchanged", 32'(irq_o), 32'h1);

    // R2: status removed drops the output after one edge
    status_i = '0;
    @(negedge clk);
    check(irq_o == '0, "R2 status cleared", 32'(irq_o), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule